// File: doc/BRIEF.md
# Spare Area Buffer Address Mapper

This block sits between the byte-stream side of a NAND flash controller and its internal buffer RAM. Software and sequencers see a page as one linear column space: the main data bytes first, then the spare (out-of-band) bytes. The buffer RAM does not store the page that way. Main data lives in contiguous 512-byte buffers. The spare bytes are split into per-chunk slices, one slice for each 512-byte chunk of main data, and each slice goes into its own 64-byte spare buffer.

For every request the mapper takes a geometry code, a column, a requested length and a spare-only flag. It returns the RAM address where the access starts and the number of bytes that can be moved from that address without crossing a buffer edge. The result is registered and appears one cycle after the request. A caller moves the returned run, advances its column by the returned length, and asks again. The RAM itself and the copy engine are outside this block.

Top module: `nfc_spare_mapper`

## Requirements
- R1: A response appears exactly one clock after `req_valid`, with `rsp_valid` high for that one cycle. While `req_valid` is low, `rsp_valid` goes low the next cycle and `rsp_addr`, `rsp_len`, `rsp_is_spare` and `rsp_err` keep their values.
- R2: `req_geom` selects the page and spare sizes: 0 = 512/16, 1 = 2048/64, 2 = 4096/128, 3 = 4096/218 (main bytes/spare bytes).
- R3: A column below the page size with `req_spare_only` low maps to main data. The response is `rsp_addr` = column, `rsp_len` = min(page size − column, `req_len`) and `rsp_is_spare` = 0, so a main run never crosses into the spare area.
- R4: A column at or above the page size is a spare access with spare offset = column − page size. With `req_spare_only` high, a column below the page size is used directly as the spare offset. Both cases set `rsp_is_spare` = 1.
- R5: The spare slice size is (spare size / (page size / 512)) rounded down to an even number. Buffer index = min(offset / slice, 7), inner offset = offset − index × slice, and `rsp_addr` = 0x1000 + index × 0x40 + inner offset.
- R6: A spare run length is min(bytes left in the buffer, `req_len`). Bytes left are slice − inner offset, except in buffer 7. Buffer 7 holds slice plus every byte the rounding left over (spare size − 7 × slice), so its bytes left are that amount − inner offset.
- R7: A spare offset at or above the spare size gives `rsp_err` = 1, `rsp_is_spare` = 1, `rsp_addr` = 0 and `rsp_len` = 0.
- R8: While `rst` is high, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| req_geom | input | 2 | Page/spare geometry code (R2) |
| req_col | input | 13 | Linear byte column within the page |
| req_len | input | 13 | Bytes the caller still wants to move |
| req_spare_only | input | 1 | Treat a column below the page size as a spare offset |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_is_spare | output | 1 | Run lies in a spare buffer |
| rsp_err | output | 1 | Spare offset is beyond the spare area |
| rsp_addr | output | 13 | Buffer RAM byte address of the run start |
| rsp_len | output | 13 | Contiguous bytes available from `rsp_addr` |

## Verification
Every geometry is swept over every column from 0 to a few bytes past the end of its spare area, in linear mode. This covers every main/spare and buffer-to-buffer boundary, and it separates a wrong slice size, a wrong clamp or a wrong address base. A second sweep sets spare-only mode over the spare-offset range. It shows that low columns are taken as spare offsets and not as main data. The requested lengths rotate through zero, one, a small value, a medium value and the maximum, so runs end at the request in some cases and at the buffer edge in others. The 4096/218 geometry is the only one where rounding leaves a remainder, and it checks that buffer 7 is enlarged. Idle cycles confirm that the outputs hold.

// File: rtl/nfc_map_pkg.sv
package nfc_map_pkg;

    localparam int COL_W  = 13;
    localparam int LEN_W  = 13;
    localparam int ADDR_W = 13;

    typedef enum logic [1:0] {
        GEOM_512_16  = 2'd0,
        GEOM_2K_64   = 2'd1,
        GEOM_4K_128  = 2'd2,
        GEOM_4K_218  = 2'd3
    } geom_e;

    typedef struct packed {
        logic [COL_W-1:0] page_bytes;
        logic [COL_W-1:0] spare_bytes;
        logic [COL_W-1:0] slice_bytes;
        logic [COL_W-1:0] last_cap;
    } geom_t;

    typedef struct packed {
        logic              is_spare;
        logic              err;
        logic [ADDR_W-1:0] addr;
        logic [LEN_W-1:0]  len;
    } map_rsp_t;

    function automatic logic [COL_W-1:0] min_col(input logic [COL_W-1:0] a,
                                                 input logic [COL_W-1:0] b);
        return (a < b) ? a : b;
    endfunction

endpackage

// File: rtl/nfc_map_geom.sv
module nfc_map_geom
    import nfc_map_pkg::*;
#(
    parameter int MAIN_CHUNK = 512,
    parameter int SPARE_BUFS = 8
) (
    input  geom_e geom,
    output geom_t g
);

    logic [COL_W-1:0] page_b;
    logic [COL_W-1:0] spare_b;
    logic [COL_W-1:0] chunks;
    logic [COL_W-1:0] slice_b;

    always_comb begin
        unique case (geom)
            GEOM_512_16: begin page_b = COL_W'(512);  spare_b = COL_W'(16);  end
            GEOM_2K_64:  begin page_b = COL_W'(2048); spare_b = COL_W'(64);  end
            GEOM_4K_128: begin page_b = COL_W'(4096); spare_b = COL_W'(128); end
            default:     begin page_b = COL_W'(4096); spare_b = COL_W'(218); end
        endcase
        chunks  = page_b / COL_W'(MAIN_CHUNK);
        slice_b = (spare_b / chunks) & ~COL_W'(1);
    end

    assign g.page_bytes  = page_b;
    assign g.spare_bytes = spare_b;
    assign g.slice_bytes = slice_b;
    assign g.last_cap    = spare_b - COL_W'(SPARE_BUFS - 1) * slice_b;

endmodule

// File: rtl/nfc_map_spare_loc.sv
module nfc_map_spare_loc
    import nfc_map_pkg::*;
#(
    parameter int SPARE_BUFS = 8,
    localparam int IDX_W     = $clog2(SPARE_BUFS)
) (
    input  logic [COL_W-1:0] soff,
    input  logic [COL_W-1:0] slice_b,
    output logic [IDX_W-1:0] idx,
    output logic [COL_W-1:0] inner
);

    logic [SPARE_BUFS-1:1] passed;

    for (genvar k = 1; k < SPARE_BUFS; k++) begin : g_edge
        assign passed[k] = (soff >= COL_W'(k) * slice_b);
    end

    always_comb begin
        idx = '0;
        for (int k = 1; k < SPARE_BUFS; k++) begin
            idx = idx + IDX_W'(passed[k]);
        end
        inner = soff - COL_W'(idx) * slice_b;
    end

endmodule

// File: rtl/nfc_spare_mapper.sv
module nfc_spare_mapper
    import nfc_map_pkg::*;
#(
    parameter int MAIN_CHUNK   = 512,
    parameter int SPARE_BUFS   = 8,
    parameter int SPARE_STRIDE = 64,
    parameter int SPARE_BASE   = 4096
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [1:0]        req_geom,
    input  logic [COL_W-1:0]  req_col,
    input  logic [LEN_W-1:0]  req_len,
    input  logic              req_spare_only,
    output logic              rsp_valid,
    output logic              rsp_is_spare,
    output logic              rsp_err,
    output logic [ADDR_W-1:0] rsp_addr,
    output logic [LEN_W-1:0]  rsp_len
);

    localparam int IDX_W = $clog2(SPARE_BUFS);

    geom_t            g;
    logic [IDX_W-1:0] buf_idx;
    logic [COL_W-1:0] inner;
    logic [COL_W-1:0] soff;
    logic             past_page;
    logic             in_spare;
    map_rsp_t         nxt;
    map_rsp_t         cur;
    logic             valid_q;

    nfc_map_geom #(.MAIN_CHUNK(MAIN_CHUNK), .SPARE_BUFS(SPARE_BUFS)) u_geom (
        .geom (geom_e'(req_geom)),
        .g    (g)
    );

    assign past_page = (req_col >= g.page_bytes);
    assign in_spare  = past_page || req_spare_only;
    assign soff      = past_page ? (req_col - g.page_bytes) : req_col;

    nfc_map_spare_loc #(.SPARE_BUFS(SPARE_BUFS)) u_loc (
        .soff    (soff),
        .slice_b (g.slice_bytes),
        .idx     (buf_idx),
        .inner   (inner)
    );

    always_comb begin
        logic [COL_W-1:0] cap;
        cap = (buf_idx == IDX_W'(SPARE_BUFS - 1)) ? g.last_cap : g.slice_bytes;
        nxt = '0;
        if (!in_spare) begin
            nxt.addr = req_col;
            nxt.len  = min_col(g.page_bytes - req_col, req_len);
        end else if (soff >= g.spare_bytes) begin
            nxt.is_spare = 1'b1;
            nxt.err      = 1'b1;
        end else begin
            nxt.is_spare = 1'b1;
            nxt.addr     = ADDR_W'(SPARE_BASE)
                         + ADDR_W'(buf_idx) * ADDR_W'(SPARE_STRIDE) + inner;
            nxt.len      = min_col(cap - inner, req_len);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            cur     <= '0;
        end else begin
            valid_q <= req_valid;
            if (req_valid) cur <= nxt;
        end
    end

    assign rsp_valid    = valid_q;
    assign rsp_is_spare = cur.is_spare;
    assign rsp_err      = cur.err;
    assign rsp_addr     = cur.addr;
    assign rsp_len      = cur.len;

    assert_latency_R1: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);
    assert_hold_R1: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid && $stable(rsp_addr) && $stable(rsp_len)
                       && $stable(rsp_err));
    assert_main_bound_R3: assert property (@(posedge clk) disable iff (rst)
        rsp_valid && !rsp_is_spare |->
            ({1'b0, rsp_addr} + {1'b0, rsp_len}) <= {1'b0, $past(g.page_bytes)});
    assert_spare_window_R6: assert property (@(posedge clk) disable iff (rst)
        rsp_valid && rsp_is_spare && !rsp_err |->
            rsp_addr >= ADDR_W'(SPARE_BASE) &&
            ((rsp_addr - ADDR_W'(SPARE_BASE)) % ADDR_W'(SPARE_STRIDE)) + rsp_len
                <= ADDR_W'(SPARE_STRIDE));
    assert_len_cap_R6: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> rsp_len <= $past(req_len));
    assert_err_empty_R7: assert property (@(posedge clk) disable iff (rst)
        rsp_err |-> rsp_is_spare && rsp_len == '0 && rsp_addr == '0);

endmodule

// File: tb/nfc_spare_mapper_tb.sv
module nfc_spare_mapper_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [1:0]  req_geom = 2'd0;
    logic [12:0] req_col = '0;
    logic [12:0] req_len = '0;
    logic        req_spare_only = 1'b0;
    logic        rsp_valid, rsp_is_spare, rsp_err;
    logic [12:0] rsp_addr, rsp_len;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 0;

    always #2ns clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    nfc_spare_mapper u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_geom(req_geom),
        .req_col(req_col), .req_len(req_len), .req_spare_only(req_spare_only),
        .rsp_valid(rsp_valid), .rsp_is_spare(rsp_is_spare), .rsp_err(rsp_err),
        .rsp_addr(rsp_addr), .rsp_len(rsp_len)
    );

    function automatic int pg(input int g);
        return (g == 0) ? 512 : (g == 1) ? 2048 : 4096;
    endfunction
    function automatic int sp(input int g);
        return (g == 0) ? 16 : (g == 1) ? 64 : (g == 2) ? 128 : 218;
    endfunction

    task automatic check(input string req, input int a_sp, input int a_er,
                         input int a_ad, input int a_ln, input int e_sp,
                         input int e_er, input int e_ad, input int e_ln);
        checks++;
        if (a_sp != e_sp || a_er != e_er || a_ad != e_ad || a_ln != e_ln) begin
            errors++;
            $display("FAIL %s: got spare=%0d err=%0d addr=%0h len=%0d expected spare=%0d err=%0d addr=%0h len=%0d",
                     req, a_sp, a_er, a_ad, a_ln, e_sp, e_er, e_ad, e_ln);
        end
    endtask

    task automatic run_one(input int g, input int col, input int len, input bit so);
        int p, s, sl, soff, idx, inner, cap, e_sp, e_er, e_ad, e_ln;
        string tag;
        p = pg(g); s = sp(g);
        sl = ((s / (p / 512)) / 2) * 2;
        req_valid = 1'b1; req_geom = 2'(g); req_col = 13'(col);
        req_len = 13'(len); req_spare_only = so;
        e_sp = 0; e_er = 0; e_ad = 0; e_ln = 0;
        if (col < p && !so) begin
            tag = "R3";
            e_ad = col; e_ln = (p - col < len) ? p - col : len;
        end else begin
            tag = so ? "R4/R5" : "R5/R6";
            soff = (col >= p) ? col - p : col;
            e_sp = 1;
            if (soff >= s) begin
                tag = "R7"; e_er = 1;
            end else begin
                idx = soff / sl; if (idx > 7) idx = 7;
                inner = soff - idx * sl;
                cap = (idx == 7) ? s - 7 * sl : sl;
                e_ad = 4096 + idx * 64 + inner;
                e_ln = (cap - inner < len) ? cap - inner : len;
            end
        end
        @(negedge clk);
        if (rsp_valid !== 1'b1) begin
            checks++; errors++;
            $display("FAIL R1: rsp_valid=%0b expected 1", rsp_valid);
        end
        check($sformatf("%s geom=%0d col=%0d so=%0b", tag, g, col, so),
              int'(rsp_is_spare), int'(rsp_err), int'(rsp_addr), int'(rsp_len),
              e_sp, e_er, e_ad, e_ln);
    endtask

    initial begin
        int lens[5] = '{1, 5, 300, 8191, 0};
        // R8: reset state, with a request pending
        req_valid = 1'b1; req_col = 13'd700;
        repeat (3) @(negedge clk);
        check("R8 reset", int'(rsp_is_spare), int'(rsp_err), int'(rsp_addr),
              int'(rsp_len) + int'(rsp_valid), 0, 0, 0, 0);
        rst = 1'b0; req_valid = 1'b0;
        @(negedge clk);
        // R2..R7: linear sweep over every geometry
        for (int g = 0; g < 4; g++) begin
            for (int c = 0; c < pg(g) + sp(g) + 3; c++)
                run_one(g, c, lens[c % 5], 1'b0);
            // R4: spare-only sweep
            for (int c = 0; c < sp(g) + 3; c++)
                run_one(g, c, lens[(c + 2) % 5], 1'b1);
            // R4: spare-only with a column past the page
            run_one(g, pg(g) + 1, 8191, 1'b1);
        end
        // R1: hold while idle, inputs moving
        run_one(3, 4096 + 190, 8191, 1'b0);
        req_valid = 1'b0; req_col = 13'd5; req_geom = 2'd0;
        repeat (3) @(negedge clk);
        check("R1 hold", int'(rsp_valid), int'(rsp_err), int'(rsp_addr), int'(rsp_len),
              0, 0, 4096 + 7 * 64 + 8, 28);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        wait (cyc >= 150000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: cycles=%0d expected completion", cyc);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule